// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz clock-enable pulse into a periodic one-cycle event strobe and an optional square-wave output. A free-running 15-bit binary divider advances on each enable pulse. A 4-bit rate code picks the divider stage whose rollover produces the event. A 3-bit timebase code, held in the same control byte, does two things. It changes the meaning of the two lowest non-zero rate codes, and two of its values hold the whole divider in reset.

The strobe is meant to set a periodic interrupt flag elsewhere. The square-wave output toggles on every event, so its frequency is half the event rate, and it appears only while its enable input is high. Because all stages come from one shared counter, a change of rate code does not restart the count. Events stay aligned to the number of enable pulses counted since the divider last left reset.

Top module: `rp_rate_gen`

## Requirements
- R1: The control byte `ctrl_a_i` is decoded as follows. Bits 3:0 hold the rate code and bits 6:4 hold the timebase code. Bit 7 has no effect on any output.
- R2: With rate code 0, `event_o` never goes high.
- R3: Rate codes 3 to 15 give one event every 2^(code-1) enable pulses. At 32768 pulses per second this is 8192 Hz for code 3, falling in powers of two down to 2 Hz for code 15.
- R4: With timebase code 010 (the 32 kHz base), rate code 1 gives one event every 128 pulses (256 Hz) and rate code 2 one every 256 pulses (128 Hz).
- R5: With any other running timebase code, rate code 1 gives an event on every pulse (32768 Hz) and rate code 2 on every second pulse (16384 Hz).
- R6: Timebase codes 110 and 111 hold the divider cleared. While either code is present, `event_o`, `sqw_o` and the square-wave phase stay low.
- R7: When the timebase code leaves 110/111, the first event comes on the pulse that completes one full period, counted from the first pulse after release.
- R8: `event_o` is high for exactly the one clock after the clock edge that samples the period-completing pulse. Clocks without a pulse do not advance the divider.
- R9: The square-wave phase toggles on each event. `sqw_o` equals `sqw_en_i` AND that phase, registered, so it is visible one clock after the edge.
- R10: A rate-code change while the divider runs does not restart counting. Events stay aligned to the pulse count since release.
- R11: After reset, `event_o` and `sqw_o` are low and the divider count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32768 Hz clock-enable pulse, one clock wide |
| ctrl_a_i | input | 8 | Control byte: rate code [3:0], timebase code [6:4] |
| sqw_en_i | input | 1 | Square-wave output enable |
| event_o | output | 1 | One-cycle periodic event strobe |
| sqw_o | output | 1 | Gated square wave, toggling on each event |

## Verification
The bench targets the timebase-dependent remap of rate codes 1 and 2. A design that ignored the timebase would fire at 256 Hz where 32768 Hz is expected, or the other way round. It also counts the first event after leaving a hold code. A divider not cleared by the hold, or off by one pulse, would strobe one pulse early or one period late. Further checks cover:
- the slowest code, which needs the full counter width;
- rate changes in mid-count, where a restarted divider would shift every later event;
- bursts of clocks with no pulse, which must not advance anything;
- square-wave gating and toggling against the bench's own phase model.

// File: rtl/rp_pkg.sv
package rp_pkg;
   localparam int unsigned RP_STAGE_W = 4;
   localparam logic [2:0]  RP_BASE_SLOW  = 3'b010;
   localparam logic [1:0]  RP_HOLD_HIGH  = 2'b11;

   typedef struct packed {
      logic                  en;
      logic [RP_STAGE_W-1:0] stage;
   } rp_tap_t;
endpackage

// File: rtl/rp_divider.sv
module rp_divider #(
   parameter int unsigned DIV_W = 15,
   parameter int unsigned TAPS  = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold_i,
   input  logic            tick_i,
   output logic [TAPS-1:0] roll_o
);
   logic [DIV_W-1:0] cnt_q;

   if (DIV_W < 1) begin : g_bad_w
      $error("rp_divider: DIV_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (hold_i) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   // roll_o[k]: this pulse completes a period of 2^k pulses
   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      if (k == 0) begin : g_first
         assign roll_o[k] = tick_i;
      end else if (k <= DIV_W) begin : g_real
         assign roll_o[k] = tick_i & (&cnt_q[k-1:0]);
      end else begin : g_none
         assign roll_o[k] = 1'b0;
      end
   end

   // R6: a hold code leaves the divider cleared
   a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (cnt_q == '0));
   // R8: clocks without a pulse do not move the divider
   a_r8_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rp_rate_decode.sv
module rp_rate_decode
   import rp_pkg::*;
#(
   parameter int unsigned RATE_W    = 4,
   parameter int unsigned BASE_W    = 3,
   parameter bit          LOW_REMAP = 1'b1
) (
   input  logic [RATE_W-1:0] rate_i,
   input  logic [BASE_W-1:0] base_i,
   output logic              hold_o,
   output rp_tap_t           tap_o
);
   if (RATE_W != RP_STAGE_W) begin : g_bad_rate
      $error("rp_rate_decode: RATE_W must equal RP_STAGE_W");
   end
   if (BASE_W != 3) begin : g_bad_base
      $error("rp_rate_decode: BASE_W must be 3");
   end

   logic slow_base;
   assign hold_o = (base_i[2:1] == RP_HOLD_HIGH);

   if (LOW_REMAP) begin : g_remap
      assign slow_base = (base_i == RP_BASE_SLOW);
   end else begin : g_fixed
      assign slow_base = 1'b0;
   end

   always_comb begin
      tap_o.en = (rate_i != '0) && !hold_o;
      unique case (rate_i)
         4'd0:    tap_o.stage = 4'd0;
         4'd1:    tap_o.stage = slow_base ? 4'd7 : 4'd0;
         4'd2:    tap_o.stage = slow_base ? 4'd8 : 4'd1;
         default: tap_o.stage = rate_i - 4'd1;
      endcase
   end
endmodule

// File: rtl/rp_event_out.sv
module rp_event_out (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic en_i,
   input  logic roll_i,
   input  logic sqw_en_i,
   output logic event_o,
   output logic sqw_o
);
   logic fire;
   logic phase_q;
   logic phase_d;

   assign fire    = en_i & roll_i;
   assign phase_d = hold_i ? 1'b0 : (phase_q ^ fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         event_o <= 1'b0;
         phase_q <= 1'b0;
         sqw_o   <= 1'b0;
      end else begin
         event_o <= fire & ~hold_i;
         phase_q <= phase_d;
         sqw_o   <= sqw_en_i & phase_d;
      end
   end

   // R2: no enabled stage, no event
   a_r2_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !event_o);
   // R9: phase only moves on an event or a hold
   a_r9_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !(en_i && roll_i)) |=> $stable(phase_q));
   // R9: gated off means low
   a_r9_sqw_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !sqw_en_i |=> !sqw_o);
   // R6: hold forces square wave low
   a_r6_hold_sqw: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (!sqw_o && !event_o));
endmodule

// File: rtl/rp_rate_gen.sv
module rp_rate_gen
   import rp_pkg::*;
#(
   parameter int unsigned DIV_W     = 15,
   parameter int unsigned RATE_W    = 4,
   parameter int unsigned BASE_W    = 3,
   parameter bit          LOW_REMAP = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick_i,
   input  logic [RATE_W+BASE_W:0]     ctrl_a_i,
   input  logic                       sqw_en_i,
   output logic                       event_o,
   output logic                       sqw_o
);
   localparam int unsigned TAPS = 1 << RATE_W;

   if (DIV_W < TAPS - 2) begin : g_bad_div
      $error("rp_rate_gen: DIV_W too small for the slowest rate code");
   end

   logic            hold;
   rp_tap_t         tap;
   logic [TAPS-1:0] roll;

   rp_rate_decode #(
      .RATE_W(RATE_W), .BASE_W(BASE_W), .LOW_REMAP(LOW_REMAP)
   ) u_decode (
      .rate_i (ctrl_a_i[RATE_W-1:0]),
      .base_i (ctrl_a_i[RATE_W+BASE_W-1:RATE_W]),
      .hold_o (hold),
      .tap_o  (tap)
   );

   rp_divider #(.DIV_W(DIV_W), .TAPS(TAPS)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (hold),
      .tick_i (tick_i),
      .roll_o (roll)
   );

   rp_event_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (hold),
      .en_i     (tap.en),
      .roll_i   (roll[tap.stage]),
      .sqw_en_i (sqw_en_i),
      .event_o  (event_o),
      .sqw_o    (sqw_o)
   );

   // R8: an event always follows a sampled pulse
   a_r8_event_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> !event_o);
endmodule

// File: tb/rp_rate_gen_bench.sv
module rp_rate_gen_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [7:0] ctrl_a_i = 8'h00;
   logic       sqw_en_i = 1'b0;
   logic       event_o, sqw_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_cnt = 0;
   bit m_ph = 1'b0;
   bit e_evt = 1'b0;
   bit e_sqw = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rp_rate_gen u_rp_rate_gen (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctrl_a_i(ctrl_a_i),
      .sqw_en_i(sqw_en_i), .event_o(event_o), .sqw_o(sqw_o)
   );

   function automatic int period_of(logic [7:0] c);
      logic [3:0] r = c[3:0];
      bit slow = (c[6:4] == 3'b010);
      if (r == 0) return 0;
      if (r == 1) return slow ? 128 : 1;
      if (r == 2) return slow ? 256 : 2;
      return 1 << (r - 1);
   endfunction

   function automatic string tag_of(logic [7:0] c);
      if (c[6:5] == 2'b11) return "R6";
      if (c[3:0] == 0) return "R2";
      if (c[3:0] <= 2) return (c[6:4] == 3'b010) ? "R4" : "R5";
      return "R3";
   endfunction

   task automatic check(string tag, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
      end
   endtask

   // one clock: drive at negedge, model after posedge, compare mid-cycle (R8, R9)
   task automatic cyc(logic t, logic [7:0] c, logic s, string extra = "");
      int p;
      tick_i = t; ctrl_a_i = c; sqw_en_i = s;
      @(posedge clk);
      p = period_of(c);
      if (c[6:5] == 2'b11) begin
         m_cnt = 0; m_ph = 0; e_evt = 0;
      end else begin
         e_evt = t && (p != 0) && (((m_cnt + 1) % p) == 0);
         if (t) m_cnt = (m_cnt + 1) % 32768;
         if (e_evt) m_ph = ~m_ph;
      end
      e_sqw = s & m_ph;
      #(CLK_PERIOD/4);
      check({tag_of(c), " R8 event", extra}, event_o, e_evt);
      check({"R9 sqw", extra}, sqw_o, e_sqw);
      @(negedge clk);
   endtask

   initial begin
      int first;
      int n;
      void'($urandom(32'd4242));
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11 event in reset", event_o, 1'b0);
      check("R11 sqw in reset", sqw_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: first event one full period (32 pulses, code 6) after release
      repeat (4) cyc(1'b1, 8'h66, 1'b1);
      first = 0;
      for (int i = 1; i <= 40; i++) begin
         cyc(1'b1, 8'h26, 1'b1, " R7");
         if (event_o && first == 0) first = i;
      end
      check("R7 first event index", first == 32, 1'b1);

      // R3: slowest code 15 from release, exactly one event in 16384 pulses
      cyc(1'b1, 8'h7f, 1'b0);
      n = 0;
      for (int i = 1; i <= 16384; i++) begin
         cyc(1'b1, 8'h2f, 1'b1);
         if (event_o) n++;
      end
      check("R3 code 15 single event", n == 1 && event_o == 1'b1, 1'b1);

      // R4 vs R5: code 1 on slow base and fast base
      cyc(1'b1, 8'h60, 1'b0);
      n = 0;
      for (int i = 0; i < 256; i++) begin
         cyc(1'b1, 8'h21, 1'b0);
         if (event_o) n++;
      end
      check("R4 code 1 slow base events", n == 2, 1'b1);
      n = 0;
      for (int i = 0; i < 8; i++) begin
         cyc(1'b1, 8'h01, 1'b0);
         if (event_o) n++;
      end
      check("R5 code 1 fast base events", n == 8, 1'b1);

      // R1: bit 7 has no effect; R8 idle clocks
      for (int i = 0; i < 64; i++) cyc(i[0], 8'h93, 1'b1, " R1");
      for (int i = 0; i < 20; i++) cyc(1'b0, 8'h13, 1'b1, " R8 idle");

      // R10: rate change mid-count keeps alignment
      for (int i = 0; i < 50; i++) cyc(1'b1, 8'h05, 1'b1, " R10");
      for (int i = 0; i < 50; i++) cyc(1'b1, 8'h07, 1'b1, " R10");
      for (int i = 0; i < 50; i++) cyc(1'b1, 8'h04, 1'b1, " R10");

      // random mix
      for (int b = 0; b < 40; b++) begin
         logic [7:0] c = 8'($urandom);
         logic s = 1'($urandom);
         if (($urandom % 4) != 0 && c[6:5] == 2'b11) c[6] = 1'b0;
         for (int i = 0; i < 500; i++) cyc(1'($urandom), c, s, " rnd");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule